// File: doc/BRIEF.md
# Store-to-Load Overlap Detector

This block tracks the stores issued in the current dispatch group and flags any load that may read bytes one of those stores writes. An instruction scheduler uses the flag to insert a no-op in front of the load. Each store is kept as an access size plus a two-part symbolic address. Each address part is either a signed 16-bit constant offset or a register tag, and a flag tells which. No real address is ever computed.

A load hits an entry in three cases. The operand pairs are identical. The operand pairs are identical after swapping. Or the second parts are equal, both first parts are constants, and the two byte ranges built from offset and size intersect. Stores are appended on an issue strobe. The whole table is dropped when the group ends. The hazard output is combinational and depends on the load inputs and the current table contents.

Top module: `st_ld_alias_det`

## Requirements
- R1: After reset the table is empty, and no load raises `hazard_o`.
- R2: A size code of 0, 1, 2, 3 or 4 means an access of 1, 2, 4, 8 or 16 bytes.
- R3: A load hits an entry when its first operand equals the entry's first operand and its second operand equals the entry's second operand. Two operands are equal only when both the constant flag and the 16-bit value match.
- R4: A load hits an entry when its first operand equals the entry's second operand and its second operand equals the entry's first operand.
- R5: When the second operands are equal and both first operands are constants, the offsets are read as signed. If the store offset is the lower one, the load hits when store offset plus store size exceeds the load offset. Otherwise it hits when load offset plus load size exceeds the store offset.
- R6: Ranges that only touch, or that lie apart, do not hit. Different second operands never give a range hit.
- R7: `hazard_o` is high only while `ld_valid_i` is high and at least one entry is valid.
- R8: A store strobe appends one entry holding its size and both operands. The entry takes part in comparisons from the cycle after the strobe, and not in the strobe cycle itself.
- R9: `grp_end_i` invalidates every entry at the next clock edge. A store strobed in the same cycle belongs to the ending group and is discarded with it.
- R10: The table holds five entries. A store strobed while all five are valid is ignored, and the existing entries stay intact.
- R11: A constant and a register tag with the same value are not equal. The range test needs both first operands to be constants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| st_valid_i | input | 1 | Store issue strobe |
| st_size_i | input | 3 | Store size code |
| st_a_const_i | input | 1 | Store first operand is a constant |
| st_a_i | input | 16 | Store first operand value |
| st_b_const_i | input | 1 | Store second operand is a constant |
| st_b_i | input | 16 | Store second operand value |
| grp_end_i | input | 1 | Dispatch group ends; clear the table |
| ld_valid_i | input | 1 | Candidate load present |
| ld_size_i | input | 3 | Load size code |
| ld_a_const_i | input | 1 | Load first operand is a constant |
| ld_a_i | input | 16 | Load first operand value |
| ld_b_const_i | input | 1 | Load second operand is a constant |
| ld_b_i | input | 16 | Load second operand value |
| hazard_o | output | 1 | Load may alias a tracked store |

## Verification
The assertions assume the size codes are only ever 0 to 4 while their strobe is high. Codes 5 to 7 have no defined byte count, and the overlap arithmetic would treat them as wider accesses. Every vector and directed sequence in the bench drives legal codes only. The bench also keeps stored offsets small enough that offset plus size never leaves the signed range the comparison assumes. A group-end strobe and a store strobe land in the same cycle only in the one sequence that checks the discard rule.

// File: rtl/alias_pkg.sv
package alias_pkg;
  localparam int unsigned OP_W   = 16;
  localparam int unsigned SZ_W   = 3;
  localparam int unsigned DEPTH  = 5;
  localparam int unsigned MAX_SZ = 4;

  typedef struct packed {
    logic            is_const;
    logic [OP_W-1:0] val;
  } addr_op_t;

  typedef struct packed {
    logic [SZ_W-1:0] size;
    addr_op_t        a;
    addr_op_t        b;
  } mem_ref_t;
endpackage

// File: rtl/alias_entry_cmp.sv
module alias_entry_cmp
  import alias_pkg::*;
(
  input  logic     valid_i,
  input  mem_ref_t st_ref_i,
  input  mem_ref_t ld_ref_i,
  output logic     hit_o
);
  localparam int unsigned EXT_W = OP_W + 2;

  logic signed [EXT_W-1:0] st_off, ld_off, st_len, ld_len;
  logic same_order, swapped, range_ok, overlap;

  function automatic logic signed [EXT_W-1:0] bytes_of(logic [SZ_W-1:0] code);
    logic [EXT_W-1:0] one;
    one = EXT_W'(1);
    return $signed(one << code);
  endfunction

  always_comb begin
    st_off = $signed({{2{st_ref_i.a.val[OP_W-1]}}, st_ref_i.a.val});
    ld_off = $signed({{2{ld_ref_i.a.val[OP_W-1]}}, ld_ref_i.a.val});
    st_len = bytes_of(st_ref_i.size);
    ld_len = bytes_of(ld_ref_i.size);

    same_order = (ld_ref_i.a == st_ref_i.a) && (ld_ref_i.b == st_ref_i.b);
    swapped    = (ld_ref_i.a == st_ref_i.b) && (ld_ref_i.b == st_ref_i.a);
    range_ok   = (ld_ref_i.b == st_ref_i.b) && ld_ref_i.a.is_const && st_ref_i.a.is_const;

    if (st_off < ld_off) overlap = (st_off + st_len) > ld_off;
    else                 overlap = (ld_off + ld_len) > st_off;

    hit_o = valid_i && (same_order || swapped || (range_ok && overlap));
  end
endmodule

// File: rtl/alias_store_table.sv
module alias_store_table
  import alias_pkg::*;
#(
  parameter int unsigned N = DEPTH
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     push_i,
  input  mem_ref_t push_ref_i,
  input  logic     clear_i,
  output mem_ref_t entries_o [N],
  output logic [N-1:0] valid_o
);
  localparam int unsigned CNT_W = $clog2(N + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             full, do_push;

  assign full    = (cnt_q == CNT_W'(N));
  assign do_push = push_i && !clear_i && !full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (do_push) cnt_q <= cnt_q + CNT_W'(1);
  end

  for (genvar i = 0; i < N; i++) begin : g_slot
    mem_ref_t slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               slot_q <= '0;
      else if (do_push && cnt_q == CNT_W'(i))    slot_q <= push_ref_i;
    end
    assign entries_o[i] = slot_q;
    assign valid_o[i]   = (cnt_q > CNT_W'(i));
  end

  // R10
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(N));

  // R9
  clear_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (valid_o == '0));

  // R8
  append_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clear_i && !full) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R10
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clear_i && full) |=> (valid_o == {N{1'b1}}));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !clear_i) |=> $stable(valid_o));
endmodule

// File: rtl/st_ld_alias_det.sv
module st_ld_alias_det
  import alias_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        st_valid_i,
  input  logic [2:0]  st_size_i,
  input  logic        st_a_const_i,
  input  logic [15:0] st_a_i,
  input  logic        st_b_const_i,
  input  logic [15:0] st_b_i,
  input  logic        grp_end_i,
  input  logic        ld_valid_i,
  input  logic [2:0]  ld_size_i,
  input  logic        ld_a_const_i,
  input  logic [15:0] ld_a_i,
  input  logic        ld_b_const_i,
  input  logic [15:0] ld_b_i,
  output logic        hazard_o
);
  mem_ref_t       st_ref, ld_ref;
  mem_ref_t       entries [DEPTH];
  logic [DEPTH-1:0] valid, hits;

  assign st_ref = '{size: st_size_i, a: '{st_a_const_i, st_a_i}, b: '{st_b_const_i, st_b_i}};
  assign ld_ref = '{size: ld_size_i, a: '{ld_a_const_i, ld_a_i}, b: '{ld_b_const_i, ld_b_i}};

  alias_store_table #(.N(DEPTH)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (st_valid_i),
    .push_ref_i (st_ref),
    .clear_i    (grp_end_i),
    .entries_o  (entries),
    .valid_o    (valid)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    alias_entry_cmp u_cmp (
      .valid_i  (valid[i]),
      .st_ref_i (entries[i]),
      .ld_ref_i (ld_ref),
      .hit_o    (hits[i])
    );
  end

  assign hazard_o = ld_valid_i && (|hits);

  // R7
  hazard_needs_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hazard_o |-> ld_valid_i);

  // R7
  hazard_needs_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hazard_o |-> (valid != '0));

  // R2
  st_size_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i |-> (st_size_i <= 3'(MAX_SZ)));

  // R2
  ld_size_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i |-> (ld_size_i <= 3'(MAX_SZ)));

  // R9
  clear_no_hazard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_end_i |=> !hazard_o);
endmodule

// File: tb/st_ld_alias_det_tb.sv
module st_ld_alias_det_tb;
  logic        clk = 0, rst_ni = 0;
  logic        st_valid = 0, st_ac = 0, st_bc = 0, grp_end = 0;
  logic [2:0]  st_size = 0, ld_size = 0;
  logic [15:0] st_a = 0, st_b = 0, ld_a = 0, ld_b = 0;
  logic        ld_valid = 0, ld_ac = 0, ld_bc = 0;
  logic        hazard;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  st_ld_alias_det u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .st_valid_i(st_valid), .st_size_i(st_size), .st_a_const_i(st_ac), .st_a_i(st_a),
    .st_b_const_i(st_bc), .st_b_i(st_b), .grp_end_i(grp_end),
    .ld_valid_i(ld_valid), .ld_size_i(ld_size), .ld_a_const_i(ld_ac), .ld_a_i(ld_a),
    .ld_b_const_i(ld_bc), .ld_b_i(ld_b), .hazard_o(hazard)
  );

  typedef struct packed {
    logic        ldv;
    logic [2:0]  ss;  logic sac; logic [15:0] sa; logic sbc; logic [15:0] sb;
    logic [2:0]  ls;  logic lac; logic [15:0] la; logic lbc; logic [15:0] lb;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd2, 1'b0, 16'd5,   1'b0, 16'd7, 3'd2, 1'b0, 16'd5,  1'b0, 16'd7, 1'b1, 4'd3},  // R3
    '{1'b1, 3'd2, 1'b0, 16'd5,   1'b0, 16'd7, 3'd2, 1'b0, 16'd7,  1'b0, 16'd5, 1'b1, 4'd4},  // R4
    '{1'b1, 3'd2, 1'b1, 16'd5,   1'b0, 16'd7, 3'd2, 1'b0, 16'd5,  1'b0, 16'd7, 1'b0, 4'd11}, // R11
    '{1'b1, 3'd2, 1'b1, 16'd0,   1'b0, 16'd3, 3'd0, 1'b1, 16'd2,  1'b0, 16'd3, 1'b1, 4'd5},  // R5
    '{1'b1, 3'd0, 1'b1, 16'd8,   1'b0, 16'd3, 3'd3, 1'b1, 16'd4,  1'b0, 16'd3, 1'b1, 4'd5},  // R5
    '{1'b1, 3'd2, 1'b1, 16'd0,   1'b0, 16'd3, 3'd0, 1'b1, 16'd4,  1'b0, 16'd3, 1'b0, 4'd6},  // R6
    '{1'b1, 3'd0, 1'b1, 16'd8,   1'b0, 16'd3, 3'd2, 1'b1, 16'd4,  1'b0, 16'd3, 1'b0, 4'd6},  // R6
    '{1'b1, 3'd4, 1'b1, 16'd0,   1'b0, 16'd3, 3'd0, 1'b1, 16'd15, 1'b0, 16'd3, 1'b1, 4'd2},  // R2
    '{1'b1, 3'd3, 1'b1, 16'd0,   1'b0, 16'd3, 3'd0, 1'b1, 16'd15, 1'b0, 16'd3, 1'b0, 4'd2},  // R2
    '{1'b1, 3'd3, 1'b1, 16'hFFFC,1'b0, 16'd3, 3'd0, 1'b1, 16'd2,  1'b0, 16'd3, 1'b1, 4'd5},  // R5
    '{1'b1, 3'd2, 1'b1, 16'd0,   1'b0, 16'd3, 3'd2, 1'b1, 16'd1,  1'b0, 16'd4, 1'b0, 4'd6},  // R6
    '{1'b0, 3'd2, 1'b0, 16'd5,   1'b0, 16'd7, 3'd2, 1'b0, 16'd5,  1'b0, 16'd7, 1'b0, 4'd7},  // R7
    '{1'b1, 3'd0, 1'b1, 16'd6,   1'b0, 16'd3, 3'd3, 1'b1, 16'd6,  1'b0, 16'd9, 1'b0, 4'd6}   // R6
  };

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (hazard !== exp) begin
      n_fail++;
      $display("FAIL %s: hazard_o=%b expected %b", req, hazard, exp);
    end
  endtask

  task automatic push_store(input logic [2:0] sz, input logic ac, input logic [15:0] a,
                            input logic bc, input logic [15:0] b);
    @(negedge clk);
    st_valid = 1; st_size = sz; st_ac = ac; st_a = a; st_bc = bc; st_b = b;
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic end_group();
    @(negedge clk); grp_end = 1;
    @(negedge clk); grp_end = 0;
  endtask

  task automatic probe(input logic v, input logic [2:0] sz, input logic ac, input logic [15:0] a,
                       input logic bc, input logic [15:0] b, input logic exp, input string req);
    ld_valid = v; ld_size = sz; ld_ac = ac; ld_a = a; ld_bc = bc; ld_b = b;
    #1 check(exp, req);
    ld_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    probe(1, 3'd2, 0, 16'd0, 0, 16'd0, 0, "R1");
    probe(1, 3'd2, 1, 16'd0, 1, 16'd0, 0, "R1");

    for (int i = 0; i < NV; i++) begin
      end_group();
      push_store(VECS[i].ss, VECS[i].sac, VECS[i].sa, VECS[i].sbc, VECS[i].sb);
      probe(VECS[i].ldv, VECS[i].ls, VECS[i].lac, VECS[i].la, VECS[i].lbc, VECS[i].lb,
            VECS[i].exp, $sformatf("R%0d vec%0d", VECS[i].req, i));
    end

    // R8: an entry is invisible in its strobe cycle, visible after
    end_group();
    @(negedge clk);
    st_valid = 1; st_size = 3'd2; st_ac = 0; st_a = 16'd20; st_bc = 0; st_b = 16'd21;
    probe(1, 3'd2, 0, 16'd20, 0, 16'd21, 0, "R8 same cycle");
    @(negedge clk);
    st_valid = 0;
    probe(1, 3'd2, 0, 16'd20, 0, 16'd21, 1, "R8 next cycle");

    // R9: group end clears the table
    end_group();
    @(negedge clk);
    probe(1, 3'd2, 0, 16'd20, 0, 16'd21, 0, "R9 cleared");

    // R9: a store together with group end is discarded
    @(negedge clk);
    grp_end = 1; st_valid = 1; st_size = 3'd2; st_ac = 0; st_a = 16'd30; st_bc = 0; st_b = 16'd31;
    @(negedge clk);
    grp_end = 0; st_valid = 0;
    probe(1, 3'd2, 0, 16'd30, 0, 16'd31, 0, "R9 simultaneous store");

    // R10: fill five entries, then a sixth is ignored
    end_group();
    for (int k = 1; k <= 5; k++) push_store(3'd2, 0, 16'(k), 0, 16'(k + 100));
    probe(1, 3'd2, 0, 16'd5, 0, 16'd105, 1, "R10 fifth entry");
    probe(1, 3'd2, 0, 16'd3, 0, 16'd103, 1, "R10 middle entry");
    push_store(3'd2, 0, 16'd6, 0, 16'd106);
    probe(1, 3'd2, 0, 16'd6, 0, 16'd106, 0, "R10 sixth store ignored");
    probe(1, 3'd2, 0, 16'd1, 0, 16'd101, 1, "R10 first entry intact");
    probe(1, 3'd2, 0, 16'd9, 0, 16'd109, 0, "R7 no entry matches");

    // R7: empty table after group end gives no hazard
    end_group();
    probe(1, 3'd2, 0, 16'd1, 0, 16'd101, 0, "R7 empty table");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule